// File: doc/BRIEF.md
# Grouped DMA Event Interrupt Register

This block is one 32-bit control and status register for a DMA bridge that moves data between USB buffer memory, two audio ports and main memory. Ten single-cycle event strobes arrive from the bridge. Each strobe sets its own sticky status flag. Each flag also has an enable bit that software controls. The flags that are both pending and enabled are ORed into three level-sensitive interrupt lines, and each line is registered.

Software reads the whole register to see every flag, including masked ones. It acknowledges an event by writing 0 to that event's status bit. Writing 1 to a status bit leaves the flag as it is, so a read value can be written back with only the chosen flags zeroed. Event 1 (USB address error) has a line of its own. The completion events share a second line. The audio half-buffer events share a third.

Events are numbered 0 to 9:
- 0 is USB transfer done.
- 1 is USB address error.
- 2 to 9 are audio events. Even numbers are all-done events and odd numbers are half-done events.

Top module: `evt_irq_reg`

## Requirements
- R1: After reset every status flag, every enable bit and all three interrupt lines are 0, so the register reads 0x00000000.
- R2: A pulse on event n sets its status flag. The flag is read at bit n for n<2 and at bit n+14 for n>=2. It stays set after the pulse ends.
- R3: A register write with 0 at an event's status position clears that flag. A write with 1 at that position leaves the flag unchanged and never sets it.
- R4: Every register write loads each enable bit from the written data. The enable is at bit n+8 for n<2 and at bit n+22 for n>=2. A 1 unmasks the event and a 0 masks it. The enables hold their value between writes.
- R5: A status flag reads back the same whether or not its enable is set. A pending flag that is masked does not raise any interrupt line.
- R6: Line irq[0] is high only when event 1 is pending and enabled.
- R7: Line irq[1] is high when any of events 0, 2, 4, 6 or 8 is pending and enabled.
- R8: Line irq[2] is high when any of events 3, 5, 7 or 9 is pending and enabled.
- R9: If an event pulse arrives in the same cycle as a write that clears its flag, the flag is set after that cycle.
- R10: Bits 2..7, 10..15 and all other bits outside the status and enable fields always read as 0. Writes to those bits have no effect.
- R11: Each interrupt line is registered. It rises one clock after its flag and enable are both set. It stays high until every contributing flag is cleared or masked, and falls one clock after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe, one cycle per write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Current register contents, read combinationally |
| evtPulse | input | 10 | Event strobes; bit n is event n |
| irq | output | 3 | Interrupt lines: [0] address error, [1] completions, [2] half-buffer |

## Verification
A hardware event strobe and a software acknowledge can land on the same flag in the same clock. The bench provokes this by driving an event pulse in the very cycle that a write carries 0 at that event's status position, and it does so for both a USB event and an audio event. The result is judged on the following readback: the flag must be set, and the matching interrupt line must follow one clock later. A second collision pairs a mask write with a pending flag. The line is expected to stay high for exactly one more cycle and then drop, while the flag itself stays visible.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int NUM_EVT = 10;
  localparam int NUM_IRQ = 3;
  localparam int REG_W   = 32;

  // Write decode handed from control to datapath
  typedef struct packed {
    logic               wr;     // a register write happens this cycle
    logic [NUM_EVT-1:0] stClr;  // clear request per status flag
    logic [NUM_EVT-1:0] enVal;  // new enable values (valid with wr)
  } ctrlStrb_t;

  // Register bit holding the status flag of event n
  function automatic int statusPos(input int n);
    return (n > 1) ? n + 14 : n;
  endfunction

  // Register bit holding the enable of event n
  function automatic int enablePos(input int n);
    return (n > 1) ? n + 22 : n + 8;
  endfunction

  // Interrupt line an event feeds
  function automatic int irqGroup(input int n);
    if (n == 1) return 0;
    if ((n % 2) == 0) return 1;
    return 2;
  endfunction

  function automatic logic [NUM_EVT-1:0] groupMask(input int g);
    logic [NUM_EVT-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_EVT; n++) m[n] = (irqGroup(n) == g);
    return m;
  endfunction

  function automatic logic [REG_W-1:0] validBits();
    logic [REG_W-1:0] v;
    v = '0;
    for (int n = 0; n < NUM_EVT; n++) begin
      v[statusPos(n)] = 1'b1;
      v[enablePos(n)] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import dma_evt_pkg::*;
#(
  parameter int EVT_N = NUM_EVT,
  parameter int DATA_W = REG_W
) (
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output ctrlStrb_t         strb
);
  logic [EVT_N-1:0] clrVec;
  logic [EVT_N-1:0] enVec;

  for (genvar n = 0; n < EVT_N; n++) begin : g_dec
    localparam int SP = statusPos(n);
    localparam int EP = enablePos(n);
    assign clrVec[n] = regWe & ~regWdata[SP];
    assign enVec[n]  = regWdata[EP];
  end

  assign strb.wr    = regWe;
  assign strb.stClr = clrVec;
  assign strb.enVal = enVec;
endmodule

// File: rtl/evt_dp.sv
module evt_dp
  import dma_evt_pkg::*;
#(
  parameter int EVT_N = NUM_EVT,
  parameter int LINE_N = NUM_IRQ,
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [EVT_N-1:0]  evtPulse,
  output logic [DATA_W-1:0] regRdata,
  output logic [LINE_N-1:0] irq
);
  localparam logic [DATA_W-1:0] VALID = validBits();

  logic [EVT_N-1:0] statusQ;
  logic [EVT_N-1:0] enableQ;
  logic [EVT_N-1:0] pendEn;

  // Sticky flags: a new event outranks a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~strb.stClr) | evtPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        enableQ <= '0;
    else if (strb.wr) enableQ <= strb.enVal;
  end

  assign pendEn = statusQ & enableQ;

  always_comb begin
    regRdata = '0;
    for (int n = 0; n < EVT_N; n++) begin
      regRdata[statusPos(n)] = statusQ[n];
      regRdata[enablePos(n)] = enableQ[n];
    end
  end

  for (genvar g = 0; g < LINE_N; g++) begin : g_line
    localparam logic [EVT_N-1:0] MASK = groupMask(g);
    logic lineQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lineQ <= 1'b0;
      else       lineQ <= |(pendEn & MASK);
    end
    assign irq[g] = lineQ;

    // R11: a line high now had a contributing enable set a cycle ago
    assert_line_has_enable_R11: assert property (@(posedge clk) disable iff (!rstN)
      lineQ |-> $past(|(enableQ & MASK)));
  end

  for (genvar n = 0; n < EVT_N; n++) begin : g_chk
    assert_set_on_event_R2: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[n] |=> statusQ[n]);
    assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
      (evtPulse[n] && strb.stClr[n]) |=> statusQ[n]);
    assert_clear_on_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.stClr[n] && !evtPulse[n]) |=> !statusQ[n]);
    assert_status_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.stClr[n] && !evtPulse[n]) |=> $stable(statusQ[n]));
  end

  assert_enable_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wr |=> $stable(enableQ));
  assert_addr_err_line_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq[0] |-> $past(regRdata[statusPos(1)] && regRdata[enablePos(1)]));
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata & ~VALID) == '0);
endmodule

// File: rtl/evt_irq_reg.sv
module evt_irq_reg
  import dma_evt_pkg::*;
#(
  parameter int EVT_N = NUM_EVT,
  parameter int LINE_N = NUM_IRQ,
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [EVT_N-1:0]  evtPulse,
  output logic [LINE_N-1:0] irq
);
  ctrlStrb_t strb;

  evt_ctrl #(.EVT_N(EVT_N), .DATA_W(DATA_W)) u_ctrl (
    .regWe    (regWe),
    .regWdata (regWdata),
    .strb     (strb)
  );

  evt_dp #(.EVT_N(EVT_N), .LINE_N(LINE_N), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .evtPulse (evtPulse),
    .regRdata (regRdata),
    .irq      (irq)
  );
endmodule

// File: tb/tb_evt_irq_reg.sv
module tb_evt_irq_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [9:0]  evtPulse = '0;
  logic [31:0] regRdata;
  logic [2:0]  irq;

  int nChk = 0;
  int nBad = 0;
  localparam logic [9:0] ALL = 10'h3FF;

  evt_irq_reg dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .evtPulse(evtPulse), .irq(irq)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] packReg(input logic [9:0] st, input logic [9:0] en);
    logic [31:0] r;
    r = '0;
    for (int n = 0; n < 10; n++) begin
      if (n < 2) begin r[n] = st[n]; r[n+8] = en[n]; end
      else begin r[n+14] = st[n]; r[n+22] = en[n]; end
    end
    return r;
  endfunction

  function automatic logic [2:0] irqOf(input logic [9:0] st, input logic [9:0] en);
    logic [2:0] l;
    l = '0;
    for (int n = 0; n < 10; n++) begin
      if (st[n] && en[n]) begin
        if (n == 1) l[0] = 1'b1;
        else if (n % 2 == 0) l[1] = 1'b1;
        else l[2] = 1'b1;
      end
    end
    return l;
  endfunction

  // One cycle of stimulus; returns at the next falling edge
  task automatic drive(input logic we, input logic [31:0] d, input logic [9:0] ev);
    @(negedge clk);
    regWe = we; regWdata = d; evtPulse = ev;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; evtPulse = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 readback", regRdata, 32'h0);
    chk("R1 irq", {29'd0, irq}, 32'h0);
  endtask

  task automatic t_polled();
    for (int n = 0; n < 10; n++) begin
      drive(1'b0, '0, 10'(1 << n));
      chk("R2 flag position", regRdata, packReg(10'(1 << n), '0));
      settle();
      chk("R5 masked no irq", {29'd0, irq}, 32'h0);
      drive(1'b1, '0, '0);
      chk("R3 clear by zero", regRdata, 32'h0);
    end
  endtask

  task automatic t_routing();
    drive(1'b1, packReg('0, ALL), '0);
    chk("R4 enable readback", regRdata, packReg('0, ALL));
    for (int n = 0; n < 10; n++) begin
      drive(1'b0, '0, 10'(1 << n));
      chk("R11 registered delay", {29'd0, irq}, 32'h0);
      settle();
      if (n == 1) chk("R6 line 0", {29'd0, irq}, {29'd0, irqOf(10'(1 << n), ALL)});
      else if (n % 2 == 0) chk("R7 line 1", {29'd0, irq}, {29'd0, irqOf(10'(1 << n), ALL)});
      else chk("R8 line 2", {29'd0, irq}, {29'd0, irqOf(10'(1 << n), ALL)});
      drive(1'b1, packReg('0, ALL), '0);
      settle();
      chk("R11 drops after clear", {29'd0, irq}, 32'h0);
    end
    // two sources on line 1: clearing one keeps the line up
    drive(1'b0, '0, 10'b0000010100);
    drive(1'b1, packReg(10'b0000010000, ALL), '0);
    settle();
    chk("R7 shared line held", {29'd0, irq}, 32'h2);
    drive(1'b1, packReg('0, ALL), '0);
  endtask

  task automatic t_write_one();
    drive(1'b0, '0, 10'b0000100100);
    drive(1'b1, packReg(ALL & ~10'b0000000100, ALL), '0);
    chk("R3 write one keeps", regRdata, packReg(10'b0000100000, ALL));
    settle();
    chk("R8 half-done pending", {29'd0, irq}, 32'h4);
  endtask

  task automatic t_mask();
    drive(1'b1, packReg(10'b0000100000, ALL & ~10'b0000100000), '0);
    chk("R5 masked flag visible", regRdata, packReg(10'b0000100000, ALL & ~10'b0000100000));
    chk("R11 one more cycle high", {29'd0, irq}, 32'h4);
    settle();
    chk("R11 low after mask", {29'd0, irq}, 32'h0);
    drive(1'b1, packReg(10'b0000100000, ALL), '0);
    settle();
    chk("R4 unmask raises", {29'd0, irq}, 32'h4);
    drive(1'b1, packReg('0, ALL), '0);
  endtask

  task automatic t_collide();
    drive(1'b1, packReg('0, ALL), 10'b0010000000);
    chk("R9 event beats clear (7)", regRdata, packReg(10'b0010000000, ALL));
    settle();
    chk("R9 irq after collision", {29'd0, irq}, 32'h4);
    drive(1'b1, packReg('0, ALL), 10'b0000000010);
    chk("R9 event beats clear (1)", regRdata, packReg(10'b0000000010, ALL));
    settle();
    chk("R6 address error line", {29'd0, irq}, 32'h1);
    drive(1'b1, packReg('0, ALL), '0);
  endtask

  task automatic t_reserved();
    drive(1'b1, 32'hFFFF_FFFF, '0);
    chk("R10 reserved read zero", regRdata, packReg('0, ALL));
    chk("R3 write one never sets", regRdata & packReg(ALL, '0), 32'h0);
    drive(1'b1, 32'h0000_0000, '0);
    chk("R4 mask all", regRdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    settle();
    t_reset();
    t_polled();
    t_routing();
    t_write_one();
    t_mask();
    t_collide();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule